// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break Generation

This block turns a parallel word into an asynchronous serial frame on a single output line. A frame is a low start bit, then 8 or 9 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Bit timing comes from a one-cycle baud enable made by an external divider. Every bit on the line lasts exactly one baud-enable period. The frame format is captured when a frame begins. Changing the configuration inputs while a frame is being sent has no effect on that frame.

A break request replaces normal traffic with break characters. A break character is a low start bit followed by 13 more low bits. While the request stays high, break characters follow each other with no gap. After the request drops, the character in progress finishes, the configured number of stop bits is driven high, and the line returns to idle. A break never raises the transmit-done pulse. A request that arrives during a normal frame waits until that frame has ended.

Top module: `brk_uart_tx`

## Requirements
- R1: After reset the line is high, `ready` is 1 and `txDoneIrq` is 0.
- R2: When `ready`=1, `sendReq`=1, `breakReq`=0 and `baudTick`=1 on a clock edge, a frame starts at that edge. The line goes low for one tick period (the start bit), then carries `dataIn` least significant bit first, one bit per tick period. `ready` stays 0 until the frame ends, and the line changes only at edges where `baudTick`=1.
- R3: With `nineBit`=1, `bit9In` is sent as a ninth data bit directly after data bit 7. With `nineBit`=0, exactly 8 data bits are sent.
- R4: With `parEn`=1, one parity bit follows the last data bit. With `parOdd`=0 the number of ones over the data bits (the ninth bit included) plus the parity bit is even. With `parOdd`=1 that number is odd. With `parEn`=0, no parity bit is sent.
- R5: A normal frame ends with one high stop bit when `twoStop`=0 and with two high stop bits when `twoStop`=1.
- R6: `txDoneIrq` is high for exactly one clock, in the clock after the edge that ends the last stop bit of a normal frame, and `ready` is 1 in that clock.
- R7: A break starts at a baud-tick edge where `ready`=1 and `breakReq`=1. Each break character holds the line low for 14 tick periods: a start bit plus 13 zero bits.
- R8: If `breakReq` is still 1 at the edge that ends the 13th zero bit, another break character follows at once, so the line stays low for 14·N tick periods over N characters.
- R9: If `breakReq` is 0 at that edge, the configured one or two stop bits are sent high and then the block returns to idle. No break character ever produces a `txDoneIrq` pulse.
- R10: A `breakReq` raised during a normal frame leaves that frame and its done pulse unchanged. The break starts at the first baud tick after the frame ends.
- R11: When `sendReq` and `breakReq` are both high in idle, the break is sent and the data word is not.
- R12: `nineBit`, `parEn`, `parOdd`, `twoStop`, `dataIn` and `bit9In` are sampled at the edge where a frame or break starts. Changes to them afterwards do not alter the bits of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle bit-rate enable |
| sendReq | input | 1 | Request to send a data word (level, hold until `ready` falls) |
| dataIn | input | 8 | Data bits 7..0 |
| bit9In | input | 1 | Ninth data bit |
| nineBit | input | 1 | 1 = nine data bits, 0 = eight |
| parEn | input | 1 | 1 = append a parity bit |
| parOdd | input | 1 | 1 = odd parity, 0 = even |
| twoStop | input | 1 | 1 = two stop bits, 0 = one |
| breakReq | input | 1 | Level request for break characters |
| txLine | output | 1 | Serial output, idles high |
| ready | output | 1 | 1 when idle and able to start |
| txDoneIrq | output | 1 | One-clock pulse when a normal frame completes |

## Verification
The hardest case to reach from the ports is the decision point at the end of each break character. It is the single edge where `breakReq` is sampled to choose between another character and the stop bits. It is also the edge where a wrong zero count would show up. The stimulus collects the line one bit per baud tick and drops `breakReq` at the sample of the 14th low bit of the last wanted character. It also raises the request in the middle of a normal frame, and raises it together with `sendReq`. Every random frame scrambles the configuration inputs right after the frame is accepted, so a frame that re-read those inputs would show up as wrong bits.

// File: rtl/stx_pkg.sv
package stx_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BSTART, S_BZERO, S_BSTOP
  } txState_e;

  typedef enum logic [1:0] {
    LN_MARK, LN_SPACE, LN_DATA, LN_PAR
  } lineSel_e;

  typedef struct packed {
    logic     load;
    logic     shift;
    lineSel_e lineSel;
  } txStrobe_t;

endpackage

// File: rtl/stx_ctrl.sv
module stx_ctrl
  import stx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BREAK_ZEROS = 13
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      sendReq,
  input  logic      breakReq,
  input  logic      nineBit,
  input  logic      parEn,
  input  logic      twoStop,
  output txStrobe_t strobe,
  output logic      ready,
  output logic      doneIrq
);

  localparam int MAX_CNT = (BREAK_ZEROS > DATA_W + 1) ? BREAK_ZEROS : DATA_W + 1;
  localparam int CNT_W   = $clog2(MAX_CNT);
  localparam logic [CNT_W-1:0] LAST_ZERO = CNT_W'(BREAK_ZEROS - 1);

  txState_e         state, stateD;
  logic [CNT_W-1:0] cnt, cntD;
  logic             nineQ, parQ, twoQ;
  logic             doneD;
  logic             startFrame, startBreak;
  logic [CNT_W-1:0] lastData, lastStop;

  assign startBreak = (state == S_IDLE) && baudTick && breakReq;
  assign startFrame = (state == S_IDLE) && baudTick && !breakReq && sendReq;
  assign lastData   = nineQ ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
  assign lastStop   = CNT_W'(twoQ);
  assign ready      = (state == S_IDLE);

  always_comb begin
    strobe.load  = startFrame;
    strobe.shift = (state == S_DATA) && baudTick;
    unique case (state)
      S_START, S_BSTART, S_BZERO: strobe.lineSel = LN_SPACE;
      S_DATA:                     strobe.lineSel = LN_DATA;
      S_PAR:                      strobe.lineSel = LN_PAR;
      default:                    strobe.lineSel = LN_MARK;
    endcase
  end

  always_comb begin
    stateD = state;
    cntD   = cnt;
    doneD  = 1'b0;
    if (baudTick) begin
      unique case (state)
        S_IDLE: begin
          cntD = '0;
          if (breakReq)     stateD = S_BSTART;
          else if (sendReq) stateD = S_START;
        end
        S_START: begin
          stateD = S_DATA;
          cntD   = '0;
        end
        S_DATA: begin
          if (cnt == lastData) begin
            stateD = parQ ? S_PAR : S_STOP;
            cntD   = '0;
          end else begin
            cntD = cnt + 1'b1;
          end
        end
        S_PAR: begin
          stateD = S_STOP;
          cntD   = '0;
        end
        S_STOP: begin
          if (cnt == lastStop) begin
            stateD = S_IDLE;
            doneD  = 1'b1;
          end else begin
            cntD = cnt + 1'b1;
          end
        end
        S_BSTART: begin
          stateD = S_BZERO;
          cntD   = '0;
        end
        S_BZERO: begin
          if (cnt == LAST_ZERO) begin
            stateD = breakReq ? S_BSTART : S_BSTOP;
            cntD   = '0;
          end else begin
            cntD = cnt + 1'b1;
          end
        end
        S_BSTOP: begin
          if (cnt == lastStop) stateD = S_IDLE;
          else                 cntD = cnt + 1'b1;
        end
        default: stateD = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      doneIrq <= 1'b0;
      nineQ   <= 1'b0;
      parQ    <= 1'b0;
      twoQ    <= 1'b0;
    end else begin
      state   <= stateD;
      cnt     <= cntD;
      doneIrq <= doneD;
      if (startFrame || startBreak) begin
        nineQ <= nineBit;
        parQ  <= parEn;
        twoQ  <= twoStop;
      end
    end
  end

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  p_irq_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> ready);

  p_brk_noirq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BSTOP && baudTick) |=> !doneIrq);

  p_brk_rearm_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BZERO && baudTick && cnt == LAST_ZERO && breakReq)
      |=> (state == S_BSTART));

  p_zero_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BZERO) |-> (cnt <= LAST_ZERO));

endmodule

// File: rtl/stx_datapath.sv
module stx_datapath
  import stx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strobe,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              bit9In,
  input  logic              nineBit,
  input  logic              parOdd,
  output logic              txLine
);

  localparam int SH_W = DATA_W + 1;

  logic [SH_W-1:0] shiftReg;
  logic            parBit;
  logic            topBit;

  assign topBit = bit9In & nineBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= {topBit, dataIn};
      parBit   <= (^dataIn) ^ topBit ^ parOdd;
    end else if (strobe.shift) begin
      shiftReg <= {1'b0, shiftReg[SH_W-1:1]};
    end
  end

  always_comb begin
    unique case (strobe.lineSel)
      LN_SPACE: txLine = 1'b0;
      LN_DATA:  txLine = shiftReg[0];
      LN_PAR:   txLine = parBit;
      default:  txLine = 1'b1;
    endcase
  end

  p_load_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load && strobe.shift));

endmodule

// File: rtl/brk_uart_tx.sv
module brk_uart_tx
  import stx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int BREAK_ZEROS = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              sendReq,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              bit9In,
  input  logic              nineBit,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              twoStop,
  input  logic              breakReq,
  output logic              txLine,
  output logic              ready,
  output logic              txDoneIrq
);

  txStrobe_t strobe;

  stx_ctrl #(.DATA_W(DATA_W), .BREAK_ZEROS(BREAK_ZEROS)) u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .sendReq(sendReq),
    .breakReq(breakReq), .nineBit(nineBit), .parEn(parEn),
    .twoStop(twoStop), .strobe(strobe), .ready(ready), .doneIrq(txDoneIrq)
  );

  stx_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .dataIn(dataIn),
    .bit9In(bit9In), .nineBit(nineBit), .parOdd(parOdd), .txLine(txLine)
  );

  p_line_steady_r2: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> $stable(txLine));

  p_ready_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !baudTick) |=> ready);

endmodule

// File: tb/brk_uart_tx_bench.sv
module brk_uart_tx_bench;

  logic clk = 1'b0;
  logic rstN;
  logic [1:0] divCnt;
  logic baudTick;
  logic sendReq, bit9In, nineBit, parEn, parOdd, twoStop, breakReq;
  logic [7:0] dataIn;
  logic txLine, ready, txDoneIrq;

  int checks = 0;
  int fails = 0;
  int irqSeen = 0;
  int irqExp = 0;
  int cycles = 0;
  int unsigned seedDummy;

  always #10 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else       divCnt <= divCnt + 2'd1;
  end
  assign baudTick = rstN && (divCnt == 2'd3);

  brk_uart_tx u_brk_uart_tx (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .sendReq(sendReq),
    .dataIn(dataIn), .bit9In(bit9In), .nineBit(nineBit), .parEn(parEn),
    .parOdd(parOdd), .twoStop(twoStop), .breakReq(breakReq),
    .txLine(txLine), .ready(ready), .txDoneIrq(txDoneIrq)
  );

  always @(posedge clk) begin
    if (rstN && txDoneIrq) irqSeen++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic void expFrame(input logic [7:0] d, input logic b9,
      input logic nine, input logic pe, input logic po, input logic ts,
      output logic [15:0] bits, output int len);
    bits = '1;
    bits[0] = 1'b0;
    len = 1;
    for (int i = 0; i < 8; i++) begin bits[len] = d[i]; len++; end
    if (nine) begin bits[len] = b9; len++; end
    if (pe) begin bits[len] = (^d) ^ (nine & b9) ^ po; len++; end
    len += ts ? 2 : 1;
  endfunction

  task automatic getBit(output logic b, output logic busy);
    do @(negedge clk); while (!baudTick);
    b = txLine;
    busy = !ready;
  endtask

  task automatic scramble();
    dataIn  = 8'($urandom);
    bit9In  = 1'($urandom);
    nineBit = 1'($urandom);
    parEn   = 1'($urandom);
    parOdd  = 1'($urandom);
    twoStop = 1'($urandom);
  endtask

  // R2 R3 R4 R5 R6 R12: one normal frame, configuration scrambled after accept
  task automatic runFrame(input logic [7:0] d, input logic b9, input logic nine,
      input logic pe, input logic po, input logic ts, input bit brkAfter);
    logic [15:0] exp, got;
    int len;
    logic b, busy;
    expFrame(d, b9, nine, pe, po, ts, exp, len);
    @(negedge clk);
    dataIn = d; bit9In = b9; nineBit = nine; parEn = pe; parOdd = po;
    twoStop = ts; sendReq = 1'b1;
    do @(negedge clk); while (ready);
    sendReq = 1'b0;
    scramble();
    if (brkAfter) breakReq = 1'b1;
    got = '1;
    busy = 1'b0;
    for (int i = 0; i < len; i++) begin
      getBit(b, busy);
      got[i] = b;
    end
    check(got == exp && busy, "R2/R3/R4/R5/R12 frame bits", {15'd0, busy, got},
          {16'd1, exp});
    @(negedge clk);
    check(txDoneIrq && ready, "R6 done pulse", {txDoneIrq, ready}, 2'b11);
    irqExp++;
    @(negedge clk);
    check(!txDoneIrq, "R6 pulse width", txDoneIrq, 0);
  endtask

  // R7 R8 R9: n break characters then stop bits
  task automatic breakBody(input int n, input logic ts);
    logic b, busy;
    int lowBad;
    for (int k = 1; k <= n; k++) begin
      lowBad = 0;
      for (int j = 1; j <= 14; j++) begin
        getBit(b, busy);
        if (b !== 1'b0 || !busy) lowBad++;
        if (j == 14 && k == n) breakReq = 1'b0;
      end
      check(lowBad == 0, (k == 1) ? "R7 break low run" : "R8 repeated break",
            lowBad, 0);
    end
    lowBad = 0;
    for (int s = 0; s < (ts ? 2 : 1); s++) begin
      getBit(b, busy);
      if (b !== 1'b1 || !busy) lowBad++;
    end
    check(lowBad == 0, "R9 break stop bits", lowBad, 0);
    @(negedge clk);
    check(ready && !txDoneIrq, "R9 idle after break", {ready, txDoneIrq}, 2'b10);
  endtask

  task automatic sendBreak(input int n, input logic ts, input bit withSend);
    @(negedge clk);
    twoStop = ts; breakReq = 1'b1; sendReq = withSend; dataIn = 8'hFF;
    do @(negedge clk); while (ready);
    sendReq = 1'b0;
    twoStop = ~ts;  // R12: ignored once the break has started
    breakBody(n, ts);
  endtask

  initial begin
    int waitN;
    seedDummy = $urandom(32'h1d5e_e7a3);
    rstN = 1'b0; sendReq = 1'b0; breakReq = 1'b0;
    dataIn = '0; bit9In = 1'b0; nineBit = 1'b0; parEn = 1'b0;
    parOdd = 1'b0; twoStop = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(txLine && ready && !txDoneIrq, "R1 reset state",
          {txLine, ready, txDoneIrq}, 3'b110);

    // directed frames
    runFrame(8'hA5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);  // R2 8N1
    runFrame(8'h01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);  // R3 R4 odd, two stops
    runFrame(8'h7F, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);  // R4 even incl. ninth
    runFrame(8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);  // R4 R5
    runFrame(8'hFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);  // R3 ninth bit zero

    // R7 R9 single break, one stop; R8 three chars, two stops
    sendBreak(1, 1'b0, 1'b0);
    sendBreak(3, 1'b1, 1'b0);
    // R11: both requests together
    sendBreak(2, 1'b0, 1'b1);

    // R10: break requested mid-frame
    runFrame(8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    twoStop = 1'b1; sendReq = 1'b0;
    waitN = 0;
    while (ready) begin @(negedge clk); waitN++; end
    check(waitN <= 4, "R10 break follows frame", waitN, 4);
    breakBody(1, 1'b1);

    // random frames
    for (int r = 0; r < 40; r++) begin
      runFrame(8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), 1'b0);
    end

    repeat (8) @(negedge clk);
    // R6 R9: pulses only for normal frames
    check(irqSeen == irqExp, "R9 no done pulse for breaks", irqSeen, irqExp);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule